// File: doc/BRIEF.md
# Latched Interrupt Aggregator with Set/Clear Masks

This block is a second-level interrupt controller. It gathers a vector of interrupt sources (32 by default, one bit each) and raises a single request to a parent controller. Software sees a small memory-mapped register port with address, write enable, write data, read enable and read data. Each source is enabled or disabled through two separate write-one registers: one that disables sources and one that enables them. A read-only view returns the current mask.

A build parameter picks one of two variants. The latched variant turns each rising edge of a synchronised input into a sticky pending bit, which software acknowledges through a write-one-to-clear register. The level variant reports the synchronised input levels directly and has no acknowledge register. In both variants the request to the parent is high whenever a status bit is set while its mask bit is 0.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask bit reads 1 (source disabled), every status bit reads 0 and irqOut is low.
- R2: A write to the mask-set register sets each mask bit whose data bit is 1 and leaves mask bits written with 0 unchanged; a write of all ones disables every source.
- R3: A write to the mask-clear register clears each mask bit whose data bit is 1 and leaves mask bits written with 0 unchanged.
- R4: irqOut is high exactly when some status bit is 1 while the same mask bit is 0.
- R5: In the latched variant a source becomes pending on a 0-to-1 transition of its input after a two-flop synchroniser; an input that stays high does not set the bit again once it is acknowledged.
- R6: In the latched variant a write to the acknowledge register clears each pending bit whose data bit is 1, bits written 0 are unaffected, all ones flushes every pending bit, and a new edge that lands in the same cycle as the acknowledge of that bit leaves it pending.
- R7: In the level variant status equals the synchronised inputs, and irqOut falls once the unmasked inputs return low.
- R8: Latched variant byte addresses: status 0x00, acknowledge 0x08, mask view 0x0C, mask set 0x10, mask clear 0x14.
- R9: Level variant byte addresses: status 0x00, mask view 0x04, mask set 0x08, mask clear 0x0C; there is no acknowledge register.
- R10: Reads of the write-only registers and of unmapped addresses return zero, and writes to read-only registers change nothing.
- R11: Read data appears on rdData in the cycle after rdEn and shows the raw status regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_SRC | Interrupt source inputs, asynchronous |
| addr | input | ADDR_W | Byte address of the register access |
| wrEn | input | 1 | Write strobe |
| wrData | input | NUM_SRC | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | NUM_SRC | Read data, valid the cycle after rdEn |
| irqOut | output | 1 | Combined request to the parent controller |

## Verification
The assertions assume that a single bus cycle is either a read or a write, and that the address stays put while a strobe is high, so a mask write or acknowledge is attributed to exactly one clock edge. They also take the source inputs as changing no faster than the synchroniser can follow. The stimulus holds each new input pattern for several clocks before looking at status, drives every bus access for one full cycle from the falling edge, and never raises read and write together.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2
  } rdSel_e;

  // Strobes passed from address decode to the datapath
  typedef struct packed {
    logic   clrPend;
    logic   setMask;
    logic   clrMask;
    logic   rdStrobe;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit LATCH_EDGE = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobes_t          strb
);

  localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_ACK    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_MVIEW  = LATCH_EDGE ? ADDR_W'(12) : ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_MSET   = LATCH_EDGE ? ADDR_W'(16) : ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_MCLR   = LATCH_EDGE ? ADDR_W'(20) : ADDR_W'(12);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (LATCH_EDGE && addr == OFS_ACK) strb.clrPend = 1'b1;
      if (addr == OFS_MSET)              strb.setMask = 1'b1;
      if (addr == OFS_MCLR)              strb.clrMask = 1'b1;
    end
    strb.rdStrobe = rdEn;
    if (addr == OFS_STATUS)     strb.rdSel = RD_STATUS;
    else if (addr == OFS_MVIEW) strb.rdSel = RD_MASK;
    else                        strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqagg_datapath.sv
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit LATCH_EDGE  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  strobes_t           strb,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] maskVec
);

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] syncQ;
  logic [NUM_SRC-1:0] syncLvl;
  logic [NUM_SRC-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end
  assign syncLvl = syncQ[SYNC_STAGES-1];

  generate
    if (LATCH_EDGE) begin : g_latched
      logic [NUM_SRC-1:0] prevQ;
      logic [NUM_SRC-1:0] pendQ;
      logic [NUM_SRC-1:0] riseVec;
      logic [NUM_SRC-1:0] ackVec;

      assign riseVec = syncLvl & ~prevQ;
      assign ackVec  = strb.clrPend ? wrData : '0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ <= '0;
          pendQ <= '0;
        end else begin
          prevQ <= syncLvl;
          pendQ <= (pendQ & ~ackVec) | riseVec;
        end
      end
      assign statusVec = pendQ;
    end else begin : g_level
      logic unusedAck;
      assign unusedAck = strb.clrPend;
      assign statusVec = syncLvl;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
    end else if (strb.setMask) begin
      maskQ <= maskQ | wrData;
    end else if (strb.clrMask) begin
      maskQ <= maskQ & ~wrData;
    end
  end
  assign maskVec = maskQ;

  assign irqOut = |(statusVec & ~maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdStrobe) begin
      case (strb.rdSel)
        RD_STATUS: rdData <= statusVec;
        RD_MASK:   rdData <= maskQ;
        default:   rdData <= '0;
      endcase
    end else begin
      rdData <= '0;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit LATCH_EDGE  = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               rdEn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);

  strobes_t           strb;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] maskVec;

  irqagg_ctrl #(
    .ADDR_W    (ADDR_W),
    .LATCH_EDGE(LATCH_EDGE)
  ) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .strb(strb)
  );

  irqagg_datapath #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES),
    .LATCH_EDGE (LATCH_EDGE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .wrData   (wrData),
    .strb     (strb),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .statusVec(statusVec),
    .maskVec  (maskVec)
  );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int NUM_SRC    = 32,
  parameter int ADDR_W     = 8,
  parameter bit LATCH_EDGE = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic [NUM_SRC-1:0] wrData,
  input logic               rdEn,
  input logic [NUM_SRC-1:0] rdData,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusVec,
  input logic [NUM_SRC-1:0] maskVec
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_VIEW = LATCH_EDGE ? ADDR_W'(12) : ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SET  = LATCH_EDGE ? ADDR_W'(16) : ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CLR  = LATCH_EDGE ? ADDR_W'(20) : ADDR_W'(12);

  logic setHit, clrHit;
  assign setHit = wrEn && (addr == A_SET);
  assign clrHit = wrEn && (addr == A_CLR);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    setHit |=> ((maskVec & $past(wrData)) == $past(wrData)));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(setHit || clrHit) |=> $stable(maskVec));

  assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrHit |=> ((maskVec & $past(wrData)) == '0));

  assert_all_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (&maskVec) |-> !irqOut);

  assert_wo_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr != A_STAT && addr != A_VIEW) |=> (rdData == '0));

  generate
    if (LATCH_EDGE) begin : g_sticky
      assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
        !(wrEn && addr == A_ACK) |=> ((statusVec & $past(statusVec)) == $past(statusVec)));
    end
  endgenerate

endmodule

bind irq_aggregator irqagg_checker #(
  .NUM_SRC   (NUM_SRC),
  .ADDR_W    (ADDR_W),
  .LATCH_EDGE(LATCH_EDGE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .irqOut   (irqOut),
  .statusVec(statusVec),
  .maskVec  (maskVec)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

  localparam int N = 32;
  localparam int AW = 8;
  // index 0: latched variant, index 1: level variant
  localparam logic [7:0] E_STAT = 8'h00, E_ACK = 8'h08, E_VIEW = 8'h0C, E_SET = 8'h10, E_CLR = 8'h14;
  localparam logic [7:0] L_STAT = 8'h00, L_VIEW = 8'h04, L_SET = 8'h08, L_CLR = 8'h0C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic [AW-1:0] addrB [2];
  logic wrB [2];
  logic rdB [2];
  logic [N-1:0] wdB [2];
  logic [N-1:0] rdD [2];
  logic irqO [2];

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  irq_aggregator #(.NUM_SRC(N), .ADDR_W(AW), .LATCH_EDGE(1'b1)) u_irq_aggregator (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .addr(addrB[0]), .wrEn(wrB[0]),
    .wrData(wdB[0]), .rdEn(rdB[0]), .rdData(rdD[0]), .irqOut(irqO[0]));

  irq_aggregator #(.NUM_SRC(N), .ADDR_W(AW), .LATCH_EDGE(1'b0)) u_irq_aggregator_lvl (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .addr(addrB[1]), .wrEn(wrB[1]),
    .wrData(wdB[1]), .rdEn(rdB[1]), .rdData(rdD[1]), .irqOut(irqO[1]));

  function automatic logic expIrq(input logic [N-1:0] st, input logic [N-1:0] mk);
    return |(st & ~mk);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int v, input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addrB[v] = a; wdB[v] = d; wrB[v] = 1'b1;
    @(negedge clk);
    wrB[v] = 1'b0;
  endtask

  task automatic busRead(input int v, input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addrB[v] = a; rdB[v] = 1'b1;
    @(negedge clk);
    rdB[v] = 1'b0;
    d = rdD[v];
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    logic [N-1:0] mdlPend, mdlMask, lastIn;
    void'($urandom(32'd20240611));
    for (int v = 0; v < 2; v++) begin
      addrB[v] = '0; wrB[v] = 1'b0; rdB[v] = 1'b0; wdB[v] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut latched", {31'b0, irqO[0]}, '0);
    chk("R1 irqOut level", {31'b0, irqO[1]}, '0);
    busRead(0, E_VIEW, r); chk("R1 R8 mask latched", r, '1);
    busRead(1, L_VIEW, r); chk("R1 R9 mask level", r, '1);
    busRead(0, E_STAT, r); chk("R1 status latched", r, '0);

    // R5 R11 edge captured, raw status while masked
    irqIn = 32'h0000_0005;
    settle();
    busRead(0, E_STAT, r); chk("R5 R11 pending raw", r, 32'h5);
    busRead(1, L_STAT, r); chk("R7 level status", r, 32'h5);
    chk("R4 masked quiet", {31'b0, irqO[0]}, '0);

    // R3 mask clear
    busWrite(0, E_CLR, 32'h1);
    busWrite(1, L_CLR, 32'h1);
    busRead(0, E_VIEW, r); chk("R3 mask after clear", r, 32'hFFFF_FFFE);
    chk("R4 irqOut latched", {31'b0, irqO[0]}, 32'h1);
    chk("R4 irqOut level", {31'b0, irqO[1]}, 32'h1);

    // R6 ack one bit
    busWrite(0, E_ACK, 32'h1);
    busRead(0, E_STAT, r); chk("R6 ack bit0", r, 32'h4);
    chk("R6 R4 irqOut after ack", {31'b0, irqO[0]}, '0);
    settle();
    busRead(0, E_STAT, r); chk("R5 held input no relatch", r, 32'h4);
    busWrite(0, E_ACK, 32'h0);
    busRead(0, E_STAT, r); chk("R6 zero ack no effect", r, 32'h4);

    // R9 level: address 0x08 is mask set
    busWrite(1, L_SET, 32'h1);
    busRead(1, L_VIEW, r); chk("R9 level mask set at 0x08", r, '1);
    chk("R9 level irqOut masked", {31'b0, irqO[1]}, '0);
    busWrite(1, L_CLR, 32'h1);
    chk("R7 level irqOut re-enabled", {31'b0, irqO[1]}, 32'h1);
    irqIn = 32'h0000_0004;
    settle();
    chk("R7 level irqOut drops", {31'b0, irqO[1]}, '0);
    busRead(1, L_STAT, r); chk("R7 level status follows", r, 32'h4);

    // R10 write-only / unmapped reads, read-only writes
    busRead(0, E_ACK, r);  chk("R10 read ack", r, '0);
    busRead(0, E_SET, r);  chk("R10 read mask set", r, '0);
    busRead(0, E_CLR, r);  chk("R10 read mask clear", r, '0);
    busRead(0, 8'h04, r);  chk("R10 read unmapped 0x04", r, '0);
    busRead(1, 8'h10, r);  chk("R10 level read 0x10", r, '0);
    busWrite(0, E_STAT, '1);
    busRead(0, E_STAT, r); chk("R10 status write ignored", r, 32'h4);
    busWrite(0, E_VIEW, 32'h0);
    busRead(0, E_VIEW, r); chk("R10 mask view write ignored", r, 32'hFFFF_FFFE);

    // R6 edge and ack in the same cycle: edge wins
    @(negedge clk);
    irqIn[8] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addrB[0] = E_ACK; wdB[0] = 32'h100; wrB[0] = 1'b1;
    @(negedge clk);
    wrB[0] = 1'b0;
    busRead(0, E_STAT, r); chk("R6 edge beats ack", r, 32'h104);

    // R2 disable all, R6 flush all
    busWrite(0, E_SET, '1);
    busRead(0, E_VIEW, r); chk("R2 mask set all", r, '1);
    busWrite(0, E_ACK, '1);
    busRead(0, E_STAT, r); chk("R6 flush all", r, '0);

    // random phase with model
    irqIn = '0;
    settle();
    busWrite(0, E_ACK, '1);
    busWrite(1, L_CLR, '1);
    mdlPend = '0; mdlMask = '1; lastIn = '0;
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [N-1:0] d;
      op = $urandom_range(0, 3);
      d = $urandom() & $urandom();
      case (op)
        0: begin
          irqIn = $urandom();
          settle();
          mdlPend = mdlPend | (irqIn & ~lastIn);
          lastIn = irqIn;
        end
        1: begin busWrite(0, E_SET, d); mdlMask = mdlMask | d; end
        2: begin busWrite(0, E_CLR, d); mdlMask = mdlMask & ~d; end
        default: begin busWrite(0, E_ACK, d); mdlPend = mdlPend & ~d; end
      endcase
      busRead(0, E_STAT, r); chk("R5 R6 random pending", r, mdlPend);
      chk("R4 random irqOut", {31'b0, irqO[0]}, {31'b0, expIrq(mdlPend, mdlMask)});
      if (op == 1 || op == 2) begin
        busRead(0, E_VIEW, r); chk("R2 R3 random mask", r, mdlMask);
      end
      if (op == 0) begin
        busRead(1, L_STAT, r); chk("R7 random level status", r, irqIn);
        chk("R7 random level irqOut", {31'b0, irqO[1]}, {31'b0, expIrq(irqIn, '0)});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule